// File: doc/BRIEF.md
# Serial Adapter Host Register and Interrupt Unit

This block is the processor-facing side of an asynchronous serial adapter. A host reaches five registers through a two-bit register select, a read/write line and a pair of chip selects. The registers are transmit data, receive data, status, command and control. A transfer happens once per high period of the bus phase input, and only while the device is selected. The serial framing itself lives in separate transmitter and receiver cores. This unit gives the transmitter each byte the host writes. It holds each byte the receiver delivers, together with that byte's error flags, until the host reads it.

The unit builds an eight-bit status word from several sources: the receive and transmit register conditions, the error flags, the two modem input lines and a summary interrupt bit. It drives the RTS and DTR lines from command register bits. It asserts an active-low interrupt when an enabled source is pending. Each source has its own enable bit: receive full, transmit empty and modem-line change.

Top module: `uart_host_regs`

## Requirements
- R1: After the active-low reset, command and control both read 0x00 and status reads 0x70 (with both modem lines high). irq_n, rts_n and dtr_n are all 1.
- R2: A transfer happens only on the first clock of a bus_phase high period, and only while cs_hi=1 and cs_lo_n=0. If bus_phase is held high over several clocks, there is still exactly one transfer.
- R3: rs=00 selects the data registers, 01 status, 10 command and 11 control. Command and control read back the value last written to them.
- R4: A write with rs=00 loads tx_data. It raises tx_load for exactly one clock, in the clock after the transfer, and clears status bit 4 (transmit empty). A tx_taken pulse sets bit 4 again. If a write and tx_taken fall in the same clock, bit 4 is left clear.
- R5: A rx_load pulse stores rx_data and sets status bit 3 (receive full). A read with rs=00 returns the stored byte and clears bit 3.
- R6: Status bit 0 (parity error) and bit 1 (framing error) are captured from rx_parity_err and rx_frame_err with each stored byte. A data read clears both.
- R7: A rx_load while bit 3 is set, with no data read in the same clock, is an overrun. The stored byte is kept, the new byte is dropped, and status bit 2 is set. Bit 2 is cleared by a data read.
- R8: Status bit 5 shows the level of dcd_n and bit 6 the level of dsr_n, each after a two-stage synchronizer. Any change on either line latches a modem-change flag, which a status read clears.
- R9: Status bit 7 is set and irq_n is low one clock after any of these conditions holds: (bit 3 and command bit 1), (bit 4 and command bit 2), or (modem-change and command bit 5). Both return to inactive one clock after no enabled condition remains.
- R10: rts_n is the inverse of command bit 3, and dtr_n is the inverse of command bit 0.
- R11: A write with rs=01 is a program reset. It clears command bits 4..0 and the overrun flag, and leaves control and command bits 7..5 unchanged.
- R12: A rx_load in the same clock as a data read does not overrun. The read returns the old byte, the new byte is stored, and bit 3 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_phase | input | 1 | Bus clock phase; a transfer occurs at its start |
| cs_hi | input | 1 | Active-high chip select |
| cs_lo_n | input | 1 | Active-low chip select |
| rs | input | 2 | Register select |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host (combinational on rs) |
| tx_data | output | 8 | Byte for the transmitter core |
| tx_load | output | 1 | One-clock pulse: new byte in tx_data |
| tx_taken | input | 1 | Transmitter has taken the byte |
| rx_data | input | 8 | Byte from the receiver core |
| rx_load | input | 1 | Receiver delivers rx_data |
| rx_parity_err | input | 1 | Parity error of the delivered byte |
| rx_frame_err | input | 1 | Framing error of the delivered byte |
| dcd_n | input | 1 | Carrier-detect modem line |
| dsr_n | input | 1 | Data-set-ready modem line |
| cmd_q | output | 8 | Command register contents |
| ctrl_q | output | 8 | Control register contents |
| rts_n | output | 1 | Request-to-send line |
| dtr_n | output | 1 | Data-terminal-ready line |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two things can meet in one clock: the receiver delivering a byte, and the host reading the data register. The bench forces this by raising rx_load on the very clock on which a data-register read transfers. It then expects three things: the read returns the earlier byte, status shows receive full without overrun, and a second read yields the new byte. The same idea applies to the interrupt path. The bench clears an interrupt source through a data read or data write, and judges the release of irq_n at the clock the registered summary bit should drop.

// File: rtl/uart_host_regs.sv
module uart_host_regs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_phase,
  input  logic       cs_hi,
  input  logic       cs_lo_n,
  input  logic [1:0] rs,
  input  logic       rd_wr_n,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] tx_data,
  output logic       tx_load,
  input  logic       tx_taken,
  input  logic [7:0] rx_data,
  input  logic       rx_load,
  input  logic       rx_parity_err,
  input  logic       rx_frame_err,
  input  logic       dcd_n,
  input  logic       dsr_n,
  output logic [7:0] cmd_q,
  output logic [7:0] ctrl_q,
  output logic       rts_n,
  output logic       dtr_n,
  output logic       irq_n
);

  localparam logic [1:0] A_DATA = 2'b00;
  localparam logic [1:0] A_STAT = 2'b01;
  localparam logic [1:0] A_CMD  = 2'b10;
  localparam logic [1:0] A_CTRL = 2'b11;

  logic phase_d;
  logic sel, acc;
  logic rd_data, wr_data, rd_stat, wr_stat, wr_cmd, wr_ctrl;

  logic [SYNC_STAGES:0] dcd_s, dsr_s;
  logic dcd_lvl, dsr_lvl, mdm_edge;

  logic [7:0] rxd;
  logic rx_full, pe, fe, ovr, tx_empty, mchg, irq_q;
  logic ovr_set, pending;
  logic [7:0] status;

  assign sel = cs_hi & ~cs_lo_n;
  assign acc = sel & bus_phase & ~phase_d;

  assign rd_data = acc &  rd_wr_n & (rs == A_DATA);
  assign wr_data = acc & ~rd_wr_n & (rs == A_DATA);
  assign rd_stat = acc &  rd_wr_n & (rs == A_STAT);
  assign wr_stat = acc & ~rd_wr_n & (rs == A_STAT);
  assign wr_cmd  = acc & ~rd_wr_n & (rs == A_CMD);
  assign wr_ctrl = acc & ~rd_wr_n & (rs == A_CTRL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase_d <= 1'b0;
    else        phase_d <= bus_phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dcd_s <= '1;
      dsr_s <= '1;
    end else begin
      dcd_s <= {dcd_s[SYNC_STAGES-1:0], dcd_n};
      dsr_s <= {dsr_s[SYNC_STAGES-1:0], dsr_n};
    end

  assign dcd_lvl  = dcd_s[SYNC_STAGES-1];
  assign dsr_lvl  = dsr_s[SYNC_STAGES-1];
  assign mdm_edge = (dcd_lvl ^ dcd_s[SYNC_STAGES]) | (dsr_lvl ^ dsr_s[SYNC_STAGES]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_cmd)       cmd_q       <= wdata;
      else if (wr_stat) cmd_q[4:0]  <= '0;
      if (wr_ctrl)      ctrl_q      <= wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_data  <= '0;
      tx_load  <= 1'b0;
      tx_empty <= 1'b1;
    end else begin
      tx_load <= wr_data;
      if (wr_data) begin
        tx_data  <= wdata;
        tx_empty <= 1'b0;
      end else if (tx_taken) begin
        tx_empty <= 1'b1;
      end
    end

  assign ovr_set = rx_load & rx_full & ~rd_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxd     <= '0;
      rx_full <= 1'b0;
      pe      <= 1'b0;
      fe      <= 1'b0;
    end else if (rx_load && !ovr_set) begin
      rxd     <= rx_data;
      rx_full <= 1'b1;
      pe      <= rx_parity_err;
      fe      <= rx_frame_err;
    end else if (rd_data) begin
      rx_full <= 1'b0;
      pe      <= 1'b0;
      fe      <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovr   <= 1'b0;
      mchg  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovr   <= (ovr & ~rd_data & ~wr_stat) | ovr_set;
      mchg  <= (mchg & ~rd_stat) | mdm_edge;
      irq_q <= pending;
    end

  assign pending = (rx_full & cmd_q[1]) | (tx_empty & cmd_q[2]) | (mchg & cmd_q[5]);

  assign status = {irq_q, dsr_lvl, dcd_lvl, tx_empty, rx_full, ovr, fe, pe};

  always_comb
    case (rs)
      A_DATA:  rdata = rxd;
      A_STAT:  rdata = status;
      A_CMD:   rdata = cmd_q;
      default: rdata = ctrl_q;
    endcase

  assign rts_n = ~cmd_q[3];
  assign dtr_n = ~cmd_q[0];
  assign irq_n = ~irq_q;

endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_hi,
  input logic       cs_lo_n,
  input logic       tx_load,
  input logic       rd_data,
  input logic       wr_stat,
  input logic       rx_load,
  input logic       rx_full,
  input logic       ovr,
  input logic [7:0] rxd,
  input logic [7:0] cmd_q,
  input logic [7:0] ctrl_q,
  input logic       irq_n
);

  // R2
  single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);

  // R2
  unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_hi || cs_lo_n) |=> !tx_load);

  // R5
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_load) |=> !rx_full);

  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && rx_full && !rd_data) |=> (ovr && $stable(rxd)));

  // R11
  prog_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (cmd_q[4:0] == 5'd0 && !ovr && $stable(ctrl_q)));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(cmd_q[1] | cmd_q[2] | cmd_q[5]));

endmodule

bind uart_host_regs uart_host_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
  .tx_load(tx_load), .rd_data(rd_data), .wr_stat(wr_stat),
  .rx_load(rx_load), .rx_full(rx_full), .ovr(ovr), .rxd(rxd),
  .cmd_q(cmd_q), .ctrl_q(ctrl_q), .irq_n(irq_n)
);

// File: tb/uart_host_regs_tb_top.sv
`timescale 1ns/1ps
module uart_host_regs_tb_top;

  logic clk = 0, rst_n = 0;
  logic bus_phase = 0, cs_hi = 0, cs_lo_n = 1, rd_wr_n = 1;
  logic [1:0] rs = 0;
  logic [7:0] wdata = 0, rdata, tx_data, rx_data = 0, cmd_q, ctrl_q;
  logic tx_load, tx_taken = 0, rx_load = 0, rx_parity_err = 0, rx_frame_err = 0;
  logic dcd_n = 1, dsr_n = 1, rts_n, dtr_n, irq_n;

  always #2.5 clk = ~clk;

  uart_host_regs dut_i (.*);

  typedef struct { string req; logic [7:0] exp; } item_t;
  item_t q[$];
  event smp;
  int n_tests = 0, n_fail = 0, txcnt = 0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(smp) begin
    item_t it;
    it = q.pop_front();
    check(it.req, rdata, it.exp);
  end

  always @(negedge clk) if (tx_load) txcnt++;

  task automatic bus(input logic [1:0] a, input logic rd, input logic [7:0] d,
                     input logic [7:0] exp, input string req,
                     input bit chk = 0, input int hold = 1,
                     input logic ch = 1, input logic cl = 0);
    @(negedge clk);
    cs_hi = ch; cs_lo_n = cl; rs = a; rd_wr_n = rd; wdata = d; bus_phase = 1;
    if (chk) begin
      q.push_back('{req, exp});
      #1 -> smp;
    end
    repeat (hold) @(posedge clk);
    @(negedge clk);
    bus_phase = 0; cs_hi = 0; cs_lo_n = 1; rd_wr_n = 1;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    bus(a, 1, 8'h00, exp, req, 1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus(a, 0, d, 8'h00, "", 0);
  endtask

  task automatic rx(input logic [7:0] d, input logic p, input logic f);
    @(negedge clk);
    rx_data = d; rx_parity_err = p; rx_frame_err = f; rx_load = 1;
    @(negedge clk);
    rx_load = 0; rx_parity_err = 0; rx_frame_err = 0;
  endtask

  task automatic taken();
    @(negedge clk); tx_taken = 1;
    @(negedge clk); tx_taken = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0;
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    rd(2'b01, 8'h70, "R1 status");
    rd(2'b10, 8'h00, "R1 cmd");
    rd(2'b11, 8'h00, "R1 ctrl");
    check("R1 irq_n", irq_n, 1); check("R1 rts_n", rts_n, 1); check("R1 dtr_n", dtr_n, 1);

    // R3 / R10
    wr(2'b11, 8'h5A); rd(2'b11, 8'h5A, "R3 ctrl readback");
    wr(2'b10, 8'h09); rd(2'b10, 8'h09, "R3 cmd readback");
    check("R10 rts_n", rts_n, 0); check("R10 dtr_n", dtr_n, 0);

    // R4 transmit write
    wr(2'b00, 8'hA5);
    check("R4 tx_load pulse", tx_load, 1); check("R4 tx_data", tx_data, 8'hA5);
    idle(1); check("R4 tx_load single", tx_load, 0);
    rd(2'b01, 8'h60, "R4 empty cleared");
    taken(); rd(2'b01, 8'h70, "R4 empty set");

    // R2 selection and single transfer
    c0 = txcnt;
    bus(2'b00, 0, 8'h33, 8'h00, "", 0, 1, 1, 1);
    bus(2'b00, 0, 8'h34, 8'h00, "", 0, 1, 0, 0);
    check("R2 unselected no load", 8'(txcnt - c0), 0);
    check("R2 tx_data kept", tx_data, 8'hA5);
    rd(2'b01, 8'h70, "R2 unselected status");
    bus(2'b00, 0, 8'h77, 8'h00, "", 0, 3);
    check("R2 one transfer per phase", 8'(txcnt - c0), 1);
    check("R2 held data", tx_data, 8'h77);
    taken();

    // R5 / R6 receive and errors
    rx(8'h3C, 1, 0); rd(2'b01, 8'h79, "R6 parity flag");
    rd(2'b00, 8'h3C, "R5 rx byte"); rd(2'b01, 8'h70, "R5 full cleared");
    rx(8'h0F, 0, 1); rd(2'b01, 8'h7A, "R6 framing flag");
    rd(2'b00, 8'h0F, "R5 rx byte 2"); rd(2'b01, 8'h70, "R6 errors cleared");

    // R7 overrun
    rx(8'h11, 0, 0); rx(8'h22, 0, 0);
    rd(2'b01, 8'h7C, "R7 overrun flag");
    rd(2'b00, 8'h11, "R7 old byte kept");
    rd(2'b01, 8'h70, "R7 overrun cleared");

    // R12 same-cycle load and read
    rx(8'h44, 0, 0);
    @(negedge clk);
    cs_hi = 1; cs_lo_n = 0; rs = 2'b00; rd_wr_n = 1; bus_phase = 1;
    rx_data = 8'h55; rx_load = 1;
    q.push_back('{"R12 read old byte", 8'h44});
    #1 -> smp;
    @(negedge clk);
    rx_load = 0; bus_phase = 0; cs_hi = 0; cs_lo_n = 1;
    rd(2'b01, 8'h78, "R12 full no overrun");
    rd(2'b00, 8'h55, "R12 new byte");
    rd(2'b01, 8'h70, "R12 drained");

    // R9 receive interrupt
    wr(2'b10, 8'h02); idle(2);
    check("R9 no irq while empty", irq_n, 1);
    rx(8'h66, 0, 0); idle(2);
    check("R9 rx irq", irq_n, 0);
    rd(2'b01, 8'hF8, "R9 status bit7");
    rd(2'b00, 8'h66, "R9 rx byte"); idle(1);
    check("R9 rx irq release", irq_n, 1);

    // R9 transmit interrupt
    wr(2'b10, 8'h04); idle(1);
    check("R9 tx irq", irq_n, 0);
    wr(2'b00, 8'h12); idle(1);
    check("R9 tx irq release", irq_n, 1);
    taken(); idle(1);
    check("R9 tx irq again", irq_n, 0);
    wr(2'b10, 8'h00); idle(1);
    check("R9 disable", irq_n, 1);

    // R8 modem lines
    wr(2'b10, 8'h20);
    @(negedge clk); dcd_n = 0; idle(5);
    check("R8 modem irq", irq_n, 0);
    rd(2'b01, 8'hD0, "R8 dcd low status");
    idle(2);
    check("R8 cleared by status read", irq_n, 1);
    rd(2'b01, 8'h50, "R8 status after clear");
    @(negedge clk); dsr_n = 0; dcd_n = 1; idle(5);
    rd(2'b01, 8'hB0, "R8 dsr low status");
    idle(2);
    @(negedge clk); dsr_n = 1; idle(5);
    rd(2'b01, 8'hF0, "R8 dsr high status"); idle(2);
    rd(2'b01, 8'h70, "R8 quiet");

    // R11 program reset
    wr(2'b10, 8'hEB);
    check("R11 rts on", rts_n, 0);
    rx(8'h01, 0, 0); rx(8'h02, 0, 0);
    wr(2'b01, 8'h00); idle(2);
    rd(2'b10, 8'hE0, "R11 cmd low bits cleared");
    rd(2'b11, 8'h5A, "R11 ctrl kept");
    check("R11 rts_n", rts_n, 1); check("R11 dtr_n", dtr_n, 1);
    rd(2'b01, 8'h78, "R11 overrun cleared");
    rd(2'b00, 8'h01, "R11 byte kept");
    rd(2'b01, 8'h70, "R11 final");

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule